// File: doc/BRIEF.md
# Floppy Controller Reset and Interrupt Registers

This block holds the control and status registers of a PC-style floppy controller that deal with resetting the controller and flagging interrupts. A host reaches them through a small byte-wide register port: a drive and motor control byte, two read-only status bytes, a tape byte, a rate/power byte, a rate-only configuration byte, a fixed ready status and a media-change input byte. The command sequencer sits outside the block. It passes status queries and completion interrupts in through strobes.

The controller resets in one of two ways. The host can write the control byte with its reset bit released while that bit was held low. The host can also write the rate byte with its software-reset or power-down bit set. Either way the interrupt goes up and a reply counter is armed. The next four status queries then each return a synthesized ready-change status, numbered for drive slots 0 to 3. After those, a query returns the code stored by the most recent external interrupt raise, or an invalid-query byte if no interrupt is pending.

Top module: `fdc_irq_regs`

## Requirements
- R1: After the synchronous reset input, the registers read SRA (offset 0) 0x00, SRB (offset 1) 0xC0, control byte (offset 2) 0x0C and tape byte (offset 3) 0x00. `irq`, `dataRate` and `powerDown` are all low.
- R2: A write to offset 2 stores the byte. Reading back returns bits 7:2 as written, bit 1 as 0 and bit 0 as the selected drive (written bit 0). SRB bit 0 takes written bit 4, SRB bit 1 takes written bit 5 and SRB bit 5 takes written bit 0. The other SRB bits keep their value.
- R3: A write to offset 2 with bit 2 set, while the stored bit 2 is clear, resets the controller. SRA then reads 0x80, `irq` rises and SRB reads 0xC0. The written byte is kept and selects the drive.
- R4: A write to offset 4 that is not held in reset stores the rate from bits 1:0 and the power-down bit from bit 6. If bit 7 or bit 6 is set, the controller resets: the control byte becomes 0x0C, SRB becomes 0xC0, drive 0 is selected and `irq` rises.
- R5: After any controller reset, the next four status queries return byte0 = 0xC0 OR slot, with slots 0, 1, 2, 3 in that order. Byte1 is `trackIn` and the length is 2. The first query lowers `irq`.
- R6: A status query with no reset replies left and an interrupt pending returns byte0 = (stored code AND 0xF8) OR the selected drive, byte1 = `trackIn` and length 2. It lowers `irq`.
- R7: A status query with no reset replies left and no interrupt pending returns byte0 = 0x80, byte1 = 0x00 and length 1.
- R8: An `irqRaise` pulse stores `irqCode`, sets the pending flag (SRA bit 7 and `irq`) and discards any reset replies that remain.
- R9: While the stored control bit 2 is clear, writes to offsets 3, 4 and 7 have no effect.
- R10: A write to offset 7 changes only `dataRate` (from bits 1:0). A write to offset 3 keeps only bit 2.
- R11: A read of offset 4 returns 0x80, clears `powerDown` and sets control bit 2 without resetting the controller.
- R12: A read of offset 7 returns `mediaChanged` of the selected drive in bit 7, with zeros elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe (needed for side-effecting reads) |
| busAddr | input | 3 | Register offset |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for busAddr, combinational |
| senseReq | input | 1 | Status query from the command sequencer |
| irqRaise | input | 1 | Interrupt raise request from the command sequencer |
| irqCode | input | 8 | Status code stored with a raise |
| trackIn | input | 8 | Present track of the selected drive |
| mediaChanged | input | 2 | Media-change flags, one per drive |
| senseValid | output | 1 | Query reply valid, one cycle after senseReq |
| senseByte0 | output | 8 | Reply status byte |
| senseByte1 | output | 8 | Reply track byte |
| senseLen | output | 2 | Reply length in bytes |
| irq | output | 1 | Interrupt line (pending flag) |
| dataRate | output | 2 | Selected data rate |
| powerDown | output | 1 | Power-down request |

## Verification
The bench targets the reset edge detection. A second write with the reset bit already high must not re-arm the replies, and a design that triggered on level would send `irq` back up. The bench also checks that a reading of the ready status forces bit 2 without a reset event, which a design that routed it through the reset path would turn into a spurious interrupt. It checks that a raise issued mid-drain throws away the remaining reset replies, since a wrong design would return 0xC1 where the raise code belongs. Finally it checks that writes made while held in reset leave the rate and tape bytes untouched.

// File: rtl/fdc_irq_pkg.sv
package fdc_irq_pkg;
  localparam int unsigned ADDR_SRA  = 0;
  localparam int unsigned ADDR_SRB  = 1;
  localparam int unsigned ADDR_CTL  = 2;
  localparam int unsigned ADDR_TAPE = 3;
  localparam int unsigned ADDR_RATE = 4;
  localparam int unsigned ADDR_CFG  = 7;

  typedef struct packed {
    logic ctlWr;
    logic ctlReset;
    logic tapeWr;
    logic rateWr;
    logic rateReset;
    logic cfgWr;
    logic statRd;
  } strobe_t;
endpackage

// File: rtl/fdc_irq_ctrl.sv
module fdc_irq_ctrl
  import fdc_irq_pkg::*;
#(
  parameter int unsigned REPLIES = 4,
  parameter int unsigned DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [2:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              ctlRunning,
  input  logic              curDrv,
  input  logic              senseReq,
  input  logic              irqRaise,
  input  logic [DATA_W-1:0] irqCode,
  input  logic [DATA_W-1:0] trackIn,
  output strobe_t           stb,
  output logic              irqPend,
  output logic              senseValid,
  output logic [DATA_W-1:0] senseByte0,
  output logic [DATA_W-1:0] senseByte1,
  output logic [1:0]        senseLen
);
  localparam int unsigned CNT_W = $clog2(REPLIES + 1);
  localparam logic [DATA_W-1:0] READY_CHG = DATA_W'(8'hC0);
  localparam logic [DATA_W-1:0] BAD_QUERY = DATA_W'(8'h80);

  logic [CNT_W-1:0]  replyCnt;
  logic [DATA_W-1:0] lastCode;
  logic              anyReset;

  always_comb begin
    stb.ctlWr     = busWr && (busAddr == 3'(ADDR_CTL));
    stb.ctlReset  = stb.ctlWr && !ctlRunning && busWdata[2];
    stb.tapeWr    = busWr && (busAddr == 3'(ADDR_TAPE)) && ctlRunning;
    stb.rateWr    = busWr && (busAddr == 3'(ADDR_RATE)) && ctlRunning;
    stb.rateReset = stb.rateWr && (busWdata[7] || busWdata[6]);
    stb.cfgWr     = busWr && (busAddr == 3'(ADDR_CFG)) && ctlRunning;
    stb.statRd    = busRd && (busAddr == 3'(ADDR_RATE));
    anyReset      = stb.ctlReset || stb.rateReset;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irqPend    <= 1'b0;
      replyCnt   <= '0;
      lastCode   <= '0;
      senseValid <= 1'b0;
      senseByte0 <= '0;
      senseByte1 <= '0;
      senseLen   <= '0;
    end else begin
      senseValid <= 1'b0;
      if (anyReset) begin
        irqPend  <= 1'b1;
        replyCnt <= CNT_W'(REPLIES);
        lastCode <= '0;
      end else if (senseReq) begin
        senseValid <= 1'b1;
        if (replyCnt != '0) begin
          senseByte0 <= READY_CHG | DATA_W'(REPLIES - replyCnt);
          senseByte1 <= trackIn;
          senseLen   <= 2'd2;
          replyCnt   <= replyCnt - 1'b1;
          irqPend    <= 1'b0;
        end else if (irqPend) begin
          senseByte0 <= {lastCode[DATA_W-1:3], 2'b00, curDrv};
          senseByte1 <= trackIn;
          senseLen   <= 2'd2;
          irqPend    <= 1'b0;
        end else begin
          senseByte0 <= BAD_QUERY;
          senseByte1 <= '0;
          senseLen   <= 2'd1;
        end
      end else if (irqRaise) begin
        irqPend  <= 1'b1;
        replyCnt <= '0;
        lastCode <= irqCode;
      end
    end
  end

  p_reset_arms_r5: assert property (@(posedge clk) disable iff (rst)
    anyReset |=> (irqPend && replyCnt == CNT_W'(REPLIES)));
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
    replyCnt <= CNT_W'(REPLIES));
  p_raise_clears_r8: assert property (@(posedge clk) disable iff (rst)
    (irqRaise && !anyReset && !senseReq) |=> (irqPend && replyCnt == '0));
  p_query_lowers_r6: assert property (@(posedge clk) disable iff (rst)
    (senseReq && !anyReset) |=> (senseValid && !irqPend));
endmodule

// File: rtl/fdc_irq_datapath.sv
module fdc_irq_datapath
  import fdc_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           stb,
  input  logic [2:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              irqPend,
  input  logic [1:0]        mediaChanged,
  output logic              ctlRunning,
  output logic              curDrv,
  output logic [DATA_W-1:0] busRdata,
  output logic [1:0]        dataRate,
  output logic              powerDown
);
  localparam logic [DATA_W-1:0] CTL_INIT  = DATA_W'(8'h0C);
  localparam logic [DATA_W-1:0] SRB_INIT  = DATA_W'(8'hC0);
  localparam logic [DATA_W-1:0] READY_VAL = DATA_W'(8'h80);

  logic [DATA_W-1:0] ctlReg, srbReg, tapeReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctlReg    <= CTL_INIT;
      srbReg    <= SRB_INIT;
      tapeReg   <= '0;
      dataRate  <= '0;
      powerDown <= 1'b0;
      curDrv    <= 1'b0;
    end else begin
      if (stb.ctlWr) begin
        ctlReg <= busWdata;
        curDrv <= busWdata[0];
        if (stb.ctlReset) begin
          srbReg    <= SRB_INIT;
          powerDown <= 1'b0;
        end else begin
          srbReg <= {srbReg[7:6], busWdata[0], srbReg[4:2], busWdata[5], busWdata[4]};
        end
      end
      if (stb.rateWr) begin
        dataRate  <= busWdata[1:0];
        powerDown <= busWdata[6];
        if (stb.rateReset) begin
          ctlReg <= CTL_INIT;
          srbReg <= SRB_INIT;
          curDrv <= 1'b0;
        end
      end
      if (stb.cfgWr) dataRate <= busWdata[1:0];
      if (stb.tapeWr) tapeReg <= {5'b0, busWdata[2], 2'b0};
      if (stb.statRd) begin
        powerDown <= 1'b0;
        ctlReg[2] <= 1'b1;
      end
    end
  end

  assign ctlRunning = ctlReg[2];

  always_comb begin
    unique case (busAddr)
      3'(ADDR_SRA):  busRdata = {irqPend, 7'b0};
      3'(ADDR_SRB):  busRdata = srbReg;
      3'(ADDR_CTL):  busRdata = {ctlReg[7:2], 1'b0, curDrv};
      3'(ADDR_TAPE): busRdata = tapeReg;
      3'(ADDR_RATE): busRdata = READY_VAL;
      3'(ADDR_CFG):  busRdata = {mediaChanged[curDrv], 7'b0};
      default:       busRdata = '0;
    endcase
  end

  p_stat_read_r11: assert property (@(posedge clk) disable iff (rst)
    stb.statRd |=> (ctlRunning && !powerDown));
  p_reset_srb_r3: assert property (@(posedge clk) disable iff (rst)
    (stb.ctlReset || stb.rateReset) |=> (srbReg == SRB_INIT));
  p_rate_reset_r4: assert property (@(posedge clk) disable iff (rst)
    stb.rateReset |=> (ctlReg == CTL_INIT && !curDrv));
endmodule

// File: rtl/fdc_irq_regs.sv
module fdc_irq_regs
  import fdc_irq_pkg::*;
#(
  parameter int unsigned REPLIES = 4,
  parameter int unsigned DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [2:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              senseReq,
  input  logic              irqRaise,
  input  logic [DATA_W-1:0] irqCode,
  input  logic [DATA_W-1:0] trackIn,
  input  logic [1:0]        mediaChanged,
  output logic              senseValid,
  output logic [DATA_W-1:0] senseByte0,
  output logic [DATA_W-1:0] senseByte1,
  output logic [1:0]        senseLen,
  output logic              irq,
  output logic [1:0]        dataRate,
  output logic              powerDown
);
  strobe_t stb;
  logic    ctlRunning, curDrv, irqPend;

  fdc_irq_ctrl #(.REPLIES(REPLIES), .DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rst(rst), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .ctlRunning(ctlRunning), .curDrv(curDrv),
    .senseReq(senseReq), .irqRaise(irqRaise), .irqCode(irqCode), .trackIn(trackIn),
    .stb(stb), .irqPend(irqPend), .senseValid(senseValid), .senseByte0(senseByte0),
    .senseByte1(senseByte1), .senseLen(senseLen)
  );

  fdc_irq_datapath #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rst(rst), .stb(stb), .busAddr(busAddr), .busWdata(busWdata),
    .irqPend(irqPend), .mediaChanged(mediaChanged), .ctlRunning(ctlRunning),
    .curDrv(curDrv), .busRdata(busRdata), .dataRate(dataRate), .powerDown(powerDown)
  );

  assign irq = irqPend;

  p_held_ignores_r9: assert property (@(posedge clk) disable iff (rst)
    (busWr && !ctlRunning && busAddr != 3'(ADDR_CTL))
      |=> ($stable(dataRate) && $stable(powerDown) && $stable(irq)));
endmodule

// File: tb/fdc_irq_regs_test.sv
module fdc_irq_regs_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       busWr = 1'b0, busRd = 1'b0;
  logic [2:0] busAddr = '0;
  logic [7:0] busWdata = '0, busRdata;
  logic       senseReq = 1'b0, irqRaise = 1'b0;
  logic [7:0] irqCode = '0, trackIn = 8'h05;
  logic [1:0] mediaChanged = 2'b10;
  logic       senseValid, irq, powerDown;
  logic [7:0] senseByte0, senseByte1;
  logic [1:0] senseLen, dataRate;

  int vecCount = 0, missCount = 0;
  bit done = 0;
  logic [17:0] expQ[$];
  string       tagQ[$];

  always #5 clk = ~clk;

  fdc_irq_regs uut (
    .clk(clk), .rst(rst), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .senseReq(senseReq), .irqRaise(irqRaise),
    .irqCode(irqCode), .trackIn(trackIn), .mediaChanged(mediaChanged),
    .senseValid(senseValid), .senseByte0(senseByte0), .senseByte1(senseByte1),
    .senseLen(senseLen), .irq(irq), .dataRate(dataRate), .powerDown(powerDown)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    vecCount++;
    if (act !== exp) begin
      missCount++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wrReg(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rdChk(logic [2:0] a, logic [7:0] exp, string tag);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    #1 chk(tag, busRdata, exp);
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic query(logic [7:0] e0, logic [7:0] e1, logic [1:0] len, string tag);
    expQ.push_back({e0, e1, len});
    tagQ.push_back(tag);
    @(negedge clk);
    senseReq = 1'b1;
    @(negedge clk);
    senseReq = 1'b0;
  endtask

  task automatic raise(logic [7:0] code);
    @(negedge clk);
    irqCode = code; irqRaise = 1'b1;
    @(negedge clk);
    irqRaise = 1'b0;
  endtask

  always @(posedge clk) begin
    #1;
    if (senseValid) begin
      if (expQ.size() == 0) begin
        vecCount++; missCount++;
        $display("FAIL unexpected reply: actual %02h expected none", senseByte0);
      end else begin
        logic [17:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk({t, " byte0"}, senseByte0, e[17:10]);
        chk({t, " byte1"}, senseByte1, e[9:2]);
        chk({t, " len"}, {6'b0, senseLen}, {6'b0, e[1:0]});
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      vecCount++; missCount++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 power-on values
    rdChk(3'd0, 8'h00, "R1 SRA");
    rdChk(3'd1, 8'hC0, "R1 SRB");
    rdChk(3'd2, 8'h0C, "R1 control");
    rdChk(3'd3, 8'h00, "R1 tape");
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 rate", {6'b0, dataRate}, 8'h00);
    chk("R1 powerDown", {7'b0, powerDown}, 8'h00);
    rdChk(3'd7, 8'h00, "R12 drive0 unchanged");
    // R7 nothing pending
    query(8'h80, 8'h00, 2'd1, "R7 idle query");
    // R2 enter hold with motors and drive 1
    wrReg(3'd2, 8'h31);
    rdChk(3'd1, 8'hE3, "R2 SRB follow");
    rdChk(3'd2, 8'h31, "R2 control readback");
    rdChk(3'd7, 8'h80, "R12 drive1 changed");
    chk("R2 no irq on hold", {7'b0, irq}, 8'h00);
    // R9 writes ignored while held
    wrReg(3'd4, 8'h81);
    chk("R9 rate reset ignored irq", {7'b0, irq}, 8'h00);
    chk("R9 rate ignored", {6'b0, dataRate}, 8'h00);
    wrReg(3'd7, 8'h02);
    chk("R9 cfg ignored", {6'b0, dataRate}, 8'h00);
    wrReg(3'd3, 8'hFF);
    rdChk(3'd3, 8'h00, "R9 tape ignored");
    // R3 release reset
    wrReg(3'd2, 8'h1C);
    chk("R3 irq", {7'b0, irq}, 8'h01);
    rdChk(3'd0, 8'h80, "R3 SRA");
    rdChk(3'd1, 8'hC0, "R3 SRB");
    rdChk(3'd2, 8'h1C, "R3 control");
    // R5 four reset replies then R7
    query(8'hC0, 8'h05, 2'd2, "R5 slot0");
    chk("R5 irq lowered", {7'b0, irq}, 8'h00);
    trackIn = 8'h11;
    query(8'hC1, 8'h11, 2'd2, "R5 slot1");
    query(8'hC2, 8'h11, 2'd2, "R5 slot2");
    query(8'hC3, 8'h11, 2'd2, "R5 slot3");
    query(8'h80, 8'h00, 2'd1, "R7 after drain");
    // R10
    wrReg(3'd7, 8'hFF);
    chk("R10 cfg rate", {6'b0, dataRate}, 8'h03);
    chk("R10 cfg no powerDown", {7'b0, powerDown}, 8'h00);
    wrReg(3'd3, 8'hFF);
    rdChk(3'd3, 8'h04, "R10 tape bit");
    // R8 / R6
    raise(8'h24);
    chk("R8 irq", {7'b0, irq}, 8'h01);
    query(8'h20, 8'h11, 2'd2, "R6 raised query");
    chk("R6 irq lowered", {7'b0, irq}, 8'h00);
    // second write with reset bit already high: no reset
    wrReg(3'd2, 8'h1D);
    chk("R3 no level reset", {7'b0, irq}, 8'h00);
    rdChk(3'd1, 8'hE1, "R2 SRB second");
    // R4 software reset
    wrReg(3'd4, 8'h81);
    chk("R4 irq", {7'b0, irq}, 8'h01);
    rdChk(3'd2, 8'h0C, "R4 control");
    rdChk(3'd1, 8'hC0, "R4 SRB");
    chk("R4 rate", {6'b0, dataRate}, 8'h01);
    query(8'hC0, 8'h11, 2'd2, "R5 after soft reset");
    raise(8'h27);
    query(8'h20, 8'h11, 2'd2, "R8 replies discarded");
    query(8'h80, 8'h00, 2'd1, "R8 then idle");
    // R4 power-down path, R11
    wrReg(3'd4, 8'h42);
    chk("R4 powerDown", {7'b0, powerDown}, 8'h01);
    chk("R4 pd irq", {7'b0, irq}, 8'h01);
    chk("R4 pd rate", {6'b0, dataRate}, 8'h02);
    rdChk(3'd4, 8'h80, "R11 status value");
    chk("R11 powerDown cleared", {7'b0, powerDown}, 8'h00);
    query(8'hC0, 8'h11, 2'd2, "R5 after power-down");
    wrReg(3'd2, 8'h08);
    rdChk(3'd4, 8'h80, "R11 status in hold");
    rdChk(3'd2, 8'h0C, "R11 bit2 forced");
    chk("R11 no reset irq", {7'b0, irq}, 8'h00);
    wrReg(3'd2, 8'h0C);
    chk("R11 no later reset", {7'b0, irq}, 8'h00);
    repeat (4) @(negedge clk);
    chk("queue drained", 8'(expQ.size()), 8'h00);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end
endmodule